// File: doc/BRIEF.md
# Chainable Preset Binary Up Counter

This block is a synchronous binary up counter built from identical 4-bit slices. A parameter sets the number of slices, so the default of three slices gives a 12-bit counter. All slices share one clock. An active-low clear drives the whole value to zero at once, without waiting for a clock edge. An active-low load input copies the data bus into the counter on the next rising edge. Two enables control counting. The run enable goes to every slice. The carry enable enters the lowest slice and moves up the chain as a look-ahead carry.

Each slice works in one of three modes per clock edge. In LOAD, the data is copied in. In STEP, the count increases by one. In HOLD, the value stays unchanged. The mode decoder picks the mode from the inputs with fixed priority. A low load input always selects LOAD. If the load input is high, STEP is selected only when the run enable and the incoming carry are both high. Every other case selects HOLD.

From any state, each edge moves the slice to LOAD, STEP or HOLD as decided by the decoder. A low clear overrides all three modes and forces the value to zero. A slice passes the carry on to the next slice only when its incoming carry is high and it holds all ones. The carry out of the top slice is the block's terminal-count output. It lets several of these blocks be chained into a wider counter.

Top module: `casc_counter`

## Requirements
- R1: While `rst_n` is low, `count_q` is zero without any clock edge. On the first rising edge after release it is still zero.
- R2: A rising edge with `load_n` low copies `data_in` into `count_q`, whatever the levels of `run_en` and `carry_en`.
- R3: A rising edge with `load_n` high and both `run_en` and `carry_en` high advances `count_q` by exactly one.
- R4: A rising edge with `load_n` high and either enable low leaves `count_q` unchanged.
- R5: `carry_out` is high exactly when `carry_en` is high and every bit of `count_q` is one. `run_en` has no effect on it.
- R6: Counting from all ones gives all zeros on the next counting edge.
- R7: When the low 4-bit slice holds 4'b1111 and the counter advances, that slice returns to zero and the slices above it go up by one as a single value. Any higher slice that is also all ones wraps as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock shared by all slices |
| rst_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous load, active low; takes priority over both enables |
| run_en | input | 1 | Count enable fed to every slice; does not gate the carry output |
| carry_en | input | 1 | Count enable fed into the lowest slice's carry input; gates `carry_out` |
| data_in | input | 4*NUM_SLICES | Value loaded on a load edge |
| count_q | output | 4*NUM_SLICES | Current counter value |
| carry_out | output | 1 | Terminal count: high while `carry_en` is high and the counter is all ones |

## Verification
Assertions check on every clock edge that each slice obeys its mode: a load takes the data, a step adds one with wrap, and a hold keeps the value. At the top level they also check that the full counter steps as one value across slice boundaries, that `carry_out` is never high without `carry_en` or away from all ones, and that the value is zero on the edge that releases the clear. Only the bench scenarios can show the clear acting between clock edges. The same applies to a load winning over high enables, to the terminal count staying high while counting is paused by `run_en`, and to the rollover from the highest value back to zero.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
    localparam int SLICE_W = 4;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_STEP = 2'd1,
        OP_LOAD = 2'd2
    } slice_op_e;
endpackage

// File: rtl/cnt_op_decode.sv
module cnt_op_decode
    import cnt_pkg::*;
(
    input  logic      load_n,
    input  logic      run_en,
    input  logic      carry_in,
    output slice_op_e op
);
    // Fixed priority: load first, then step, else hold.
    always_comb begin
        if (!load_n)
            op = OP_LOAD;
        else if (run_en && carry_in)
            op = OP_STEP;
        else
            op = OP_HOLD;
    end
endmodule

// File: rtl/cnt_slice.sv
module cnt_slice
    import cnt_pkg::*;
#(
    parameter int W = SLICE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_n,
    input  logic         run_en,
    input  logic         carry_in,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         carry_out
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    slice_op_e op;

    cnt_op_decode u_dec (
        .load_n   (load_n),
        .run_en   (run_en),
        .carry_in (carry_in),
        .op       (op)
    );

    // State register: value of this slice.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            unique case (op)
                OP_LOAD: q <= d;
                OP_STEP: q <= q + 1'b1;
                OP_HOLD: q <= q;
                default: q <= q;
            endcase
        end
    end

    // Output process: look-ahead carry to the next slice.
    always_comb begin
        carry_out = carry_in && (q == ALL_ONES);
    end

    // R2: load edge copies the data
    a_r2_load_takes_data: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> q == $past(d));

    // R3, R6: step edge adds one with wrap
    a_r3_step_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && run_en && carry_in) |=> q == W'($past(q) + 1'b1));

    // R4: hold edge keeps the value
    a_r4_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !(run_en && carry_in)) |=> $stable(q));
endmodule

// File: rtl/casc_counter.sv
module casc_counter
    import cnt_pkg::*;
#(
    parameter int NUM_SLICES = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_n,
    input  logic                          run_en,
    input  logic                          carry_en,
    input  logic [SLICE_W*NUM_SLICES-1:0] data_in,
    output logic [SLICE_W*NUM_SLICES-1:0] count_q,
    output logic                          carry_out
);
    localparam int TOTAL_W = SLICE_W * NUM_SLICES;

    logic [NUM_SLICES:0] chain;

    assign chain[0] = carry_en;

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
        cnt_slice #(.W(SLICE_W)) u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_n    (load_n),
            .run_en    (run_en),
            .carry_in  (chain[s]),
            .d         (data_in[s*SLICE_W +: SLICE_W]),
            .q         (count_q[s*SLICE_W +: SLICE_W]),
            .carry_out (chain[s+1])
        );
    end

    assign carry_out = chain[NUM_SLICES];

    // R1: value is zero on the edge that releases the clear
    a_r1_clear_zero: assert property (@(posedge clk)
        $rose(rst_n) |-> count_q == '0);

    // R5: terminal count needs the carry enable and all ones
    a_r5_carry_gated: assert property (@(posedge clk) disable iff (!rst_n)
        carry_out |-> (carry_en && (&count_q)));

    a_r5_carry_present: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_en && (&count_q)) |-> carry_out);

    // R3, R7: the whole chained value steps as one number
    a_r7_chain_step: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && run_en && carry_en) |=> count_q == TOTAL_W'($past(count_q) + 1'b1));
endmodule

// File: tb/casc_counter_bench.sv
module casc_counter_bench;
    localparam int  NS     = 3;
    localparam int  W      = 4 * NS;
    localparam time CLK_P  = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_n = 1'b1;
    logic         run_en = 1'b0;
    logic         carry_en = 1'b0;
    logic [W-1:0] data_in = '0;
    logic [W-1:0] count_q;
    logic         carry_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [W-1:0] ref_q;
    string        ref_tag;

    always #(CLK_P/2) clk = ~clk;

    casc_counter #(.NUM_SLICES(NS)) u_casc_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_n    (load_n),
        .run_en    (run_en),
        .carry_en  (carry_en),
        .data_in   (data_in),
        .count_q   (count_q),
        .carry_out (carry_out)
    );

    // Behavioural reference: one integer-like value, updated per edge.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q   <= '0;
            ref_tag <= "R1";
        end else if (!load_n) begin
            ref_q   <= data_in;
            ref_tag <= "R2";
        end else if (run_en && carry_en) begin
            ref_q   <= ref_q + 1'b1;
            if (&ref_q)                 ref_tag <= "R6";
            else if (&ref_q[3:0])       ref_tag <= "R7";
            else                        ref_tag <= "R3";
        end else begin
            ref_tag <= "R4";
        end
    end

    task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every clock, a quarter period after the edge.
    always @(posedge clk) begin
        #(CLK_P/4);
        if (!done) begin
            check(count_q === ref_q, ref_tag, count_q, ref_q);
            check(carry_out === (carry_en && (&ref_q)), "R5",
                  W'(carry_out), W'(carry_en && (&ref_q)));
        end
    end

    task automatic drive(input bit ld_n, input bit r, input bit c, input logic [W-1:0] d, input int cycles);
        @(negedge clk);
        load_n = ld_n; run_en = r; carry_en = c; data_in = d;
        repeat (cycles - 1) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(count_q === '0, "R1", count_q, '0);
        rst_n = 1'b1;

        // R4: hold with enables low
        drive(1, 0, 0, 12'h5A5, 3);
        // R2: load with both enables low
        drive(0, 0, 0, 12'h0FD, 1);
        drive(1, 0, 0, '0, 2);
        // R3, R7: count across the low slice boundary
        drive(1, 1, 1, '0, 5);
        // R4: each enable low alone
        drive(1, 0, 1, '0, 3);
        drive(1, 1, 0, '0, 3);
        // R6, R5: approach all ones, pause there with run_en low
        drive(0, 0, 0, 12'hFFD, 1);
        drive(1, 1, 1, '0, 2);
        drive(1, 0, 1, '0, 3);
        drive(1, 1, 0, '0, 2);
        drive(1, 1, 1, '0, 3);
        // R2: load wins over high enables
        drive(0, 1, 1, 12'h3C7, 2);
        drive(1, 1, 1, '0, 4);

        // R1: clear asserted mid-count, between edges
        @(negedge clk);
        #1 rst_n = 1'b0;
        #1 check(count_q === '0, "R1", count_q, '0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1, 1, 1, '0, 3);

        // Mixed patterns
        for (int i = 0; i < 300; i++) begin
            drive(($urandom % 8) != 0, ($urandom % 4) != 0, ($urandom % 4) != 0,
                  W'($urandom), 1);
        end
        drive(0, 0, 0, 12'hFFE, 1);
        drive(1, 1, 1, '0, 4);

        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule